// File: doc/BRIEF.md
# Pipelined Radix-4 Booth Multiplier

This block multiplies two signed two's-complement operands of width W and returns the full 2W-bit signed product. The multiplier operand is examined in overlapping triplets, so only W/2 partial-product rows are formed. Each row is zero, plus or minus the multiplicand, or plus or minus twice the multiplicand. A negative row is made by inverting the selected multiple. The missing +1 goes into a separate row of single bits, one at each row's least-significant position.

Sign extension is not carried across the full product width. Each row keeps its W+1 significant bits and has its top bit flipped. One constant row, computed at elaboration, cancels the offset this introduces. The rows then pass through a tree of 4:2 compressor arrays. A leftover group of three rows uses a 3:2 array. A register bank follows every level of the tree. A final carry-propagate adder after the last register bank merges the two remaining rows.

A valid flag travels through the same register stages, so each result is marked on the output. A new operand pair may be presented on every clock cycle, with no stall.

Top module: `booth_mul_pipe`

## Requirements
- R1: When out_valid is 1, out_p equals the exact 2W-bit two's-complement product of the in_a and in_b pair that the flag belongs to. For example, with W=6, 011001 (25) times 101110 (-18) gives 111000111110 (-450).
- R2: A pair sampled with in_valid=1 at rising edge t is presented on out_p with out_valid=1 from just after edge t+LAT-1 until edge t+LAT. LAT is the number of compressor levels: the row count W/2+2 is reduced to two, with each level turning every four rows into two and a leftover three into two. LAT is 2 for W=6 and for W=8.
- R3: While rst_n is low, out_valid is 0. It stays 0 in the first cycle after rst_n rises.
- R4: Each multiplier triplet {y(2i+1), y(2i), y(2i-1)} selects its row as follows, with y(-1)=0: 000 and 111 give 0; 001 and 010 give +X; 011 gives +2X; 100 gives -2X; 101 and 110 give -X. Each row is weighted by 4^i. This is observed as the correct product for every multiplier value when the multiplicand is ±1 and ±13.
- R5: The most negative operands are handled exactly. With W=6, -32 times -32 gives +1024, -32 times 31 gives -992, and 31 times 31 gives 961.
- R6: A new pair is accepted on every cycle. Consecutive pairs each produce their own result, in input order, one per cycle.
- R7: A cycle with in_valid=0 produces out_valid=0 at its output slot, and its operands have no effect on any other result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Marks in_a and in_b as an operand pair to multiply |
| in_a | input | W | Signed multiplicand |
| in_b | input | W | Signed multiplier, Booth-recoded |
| out_valid | output | 1 | Marks out_p as a result |
| out_p | output | 2W | Signed product |

## Verification
The bench uses W=6 and streams all 4096 operand pairs back-to-back. This shows that every recoded triplet, every sign combination and the extreme values come out right under a full pipeline. Fixed multiplicands of ±1 and ±13 are swept against every multiplier. The ±1 sweep isolates the row selection and the weighting of each triplet. The ±13 sweep uses a multiple whose double crosses bit positions, which exposes errors in the inversion, the +1 bits and the flipped sign bit. Alternating valid and idle cycles with garbage operands, and a reset in the middle of a stream, separate correct valid alignment from results that are merely correct but shifted in time.

// File: rtl/booth_pkg.sv
package booth_pkg;

   // Rows left after one compressor level: groups of four become two,
   // a leftover three becomes two, a leftover one or two passes through.
   function automatic int next_rows(input int r);
      int rem;
      rem = r % 4;
      return (r / 4) * 2 + ((rem == 3) ? 2 : rem);
   endfunction

   function automatic int rows_after(input int start, input int lev);
      int r;
      r = start;
      for (int k = 0; k < lev; k++) r = next_rows(r);
      return r;
   endfunction

   function automatic int level_count(input int start);
      int r;
      int n;
      r = start;
      n = 0;
      while (r > 2) begin
         r = next_rows(r);
         n++;
      end
      return n;
   endfunction

   typedef struct packed {
      logic one;
      logic two;
      logic neg;
   } booth_sel_t;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder (
   input  logic [2:0]           trip,
   output booth_pkg::booth_sel_t sel
);
   logic hi;
   logic mid;
   logic lo;

   assign hi  = trip[2];
   assign mid = trip[1];
   assign lo  = trip[0];

   always_comb begin
      sel.one = mid ^ lo;
      sel.two = (hi & ~mid & ~lo) | (~hi & mid & lo);
      sel.neg = hi & ~(mid & lo);
   end
endmodule

// File: rtl/booth_row_gen.sv
module booth_row_gen #(
   parameter int W = 8,
   localparam int NPP = W / 2,
   localparam int NR  = NPP + 2,
   localparam int PW  = 2 * W
) (
   input  logic [W-1:0]           x,
   input  logic [W-1:0]           y,
   output logic [NR-1:0][PW-1:0]  rows_o
);
   // Cancels the 2^(W+2i) offset that flipping each row's sign bit adds.
   function automatic logic [PW-1:0] bias_row();
      logic [PW-1:0] acc;
      logic [PW-1:0] unit;
      acc  = '0;
      unit = {{(PW-1){1'b0}}, 1'b1};
      for (int i = 0; i < NPP; i++) acc = acc - (unit << (W + 2 * i));
      return acc;
   endfunction

   localparam logic [PW-1:0] BIAS = bias_row();

   logic [NPP-1:0] neg_v;

   for (genvar i = 0; i < NPP; i++) begin : g_grp
      logic [2:0]            trip;
      booth_pkg::booth_sel_t sel;
      logic [W:0]            mult;
      logic [W:0]            pp;

      if (i == 0) begin : g_first
         assign trip = {y[1], y[0], 1'b0};
      end else begin : g_rest
         assign trip = y[2*i+1 : 2*i-1];
      end

      booth_recoder u_rec (
         .trip (trip),
         .sel  (sel)
      );

      always_comb begin
         if (sel.one)      mult = {x[W-1], x};
         else if (sel.two) mult = {x, 1'b0};
         else              mult = '0;
         pp = mult ^ {(W+1){sel.neg}};
      end

      assign neg_v[i]  = sel.neg;
      assign rows_o[i] = {{(PW-W-1){1'b0}}, ~pp[W], pp[W-1:0]} << (2 * i);
   end

   always_comb begin
      rows_o[NPP] = '0;
      for (int i = 0; i < NPP; i++) rows_o[NPP][2*i] = neg_v[i];
   end

   assign rows_o[NPP+1] = BIAS;
endmodule

// File: rtl/booth_csa_rows.sv
module csa32_row #(
   parameter int PW = 16
) (
   input  logic [PW-1:0] a,
   input  logic [PW-1:0] b,
   input  logic [PW-1:0] c,
   output logic [PW-1:0] s,
   output logic [PW-1:0] co
);
   assign s  = a ^ b ^ c;
   assign co = {(a[PW-2:0] & b[PW-2:0]) | (b[PW-2:0] & c[PW-2:0]) |
                (a[PW-2:0] & c[PW-2:0]), 1'b0};
endmodule

module csa42_row #(
   parameter int PW = 16
) (
   input  logic [PW-1:0] a,
   input  logic [PW-1:0] b,
   input  logic [PW-1:0] c,
   input  logic [PW-1:0] d,
   output logic [PW-1:0] s,
   output logic [PW-1:0] co
);
   logic [PW-1:0] s1;
   logic [PW-1:0] lat;

   // First adder: its carry moves sideways into the next column.
   assign s1  = a ^ b ^ c;
   assign lat = {(a[PW-2:0] & b[PW-2:0]) | (b[PW-2:0] & c[PW-2:0]) |
                 (a[PW-2:0] & c[PW-2:0]), 1'b0};

   // Second adder: merges the partial sum, the fourth row and the side carry.
   assign s  = s1 ^ d ^ lat;
   assign co = {(s1[PW-2:0] & d[PW-2:0]) | (d[PW-2:0] & lat[PW-2:0]) |
                (s1[PW-2:0] & lat[PW-2:0]), 1'b0};
endmodule

// File: rtl/booth_ctree.sv
module booth_ctree #(
   parameter int NR = 6,
   parameter int PW = 16,
   localparam int NLEV = booth_pkg::level_count(NR)
) (
   input  logic                   clk,
   input  logic [NR-1:0][PW-1:0]  rows_i,
   output logic [PW-1:0]          sum_o,
   output logic [PW-1:0]          car_o
);
   for (genvar l = 0; l < NLEV; l++) begin : g_lev
      localparam int RI  = booth_pkg::rows_after(NR, l);
      localparam int RO  = booth_pkg::rows_after(NR, l + 1);
      localparam int NG  = RI / 4;
      localparam int REM = RI % 4;

      logic [RI-1:0][PW-1:0] src;
      logic [RO-1:0][PW-1:0] d;
      logic [RO-1:0][PW-1:0] q;

      if (l == 0) begin : g_src0
         assign src = rows_i;
      end else begin : g_srcn
         assign src = g_lev[l-1].q;
      end

      for (genvar g = 0; g < NG; g++) begin : g_c42
         csa42_row #(.PW(PW)) u_c42 (
            .a  (src[4*g]),
            .b  (src[4*g+1]),
            .c  (src[4*g+2]),
            .d  (src[4*g+3]),
            .s  (d[2*g]),
            .co (d[2*g+1])
         );
      end

      if (REM == 3) begin : g_c32
         csa32_row #(.PW(PW)) u_c32 (
            .a  (src[4*NG]),
            .b  (src[4*NG+1]),
            .c  (src[4*NG+2]),
            .s  (d[2*NG]),
            .co (d[2*NG+1])
         );
      end else if (REM == 2) begin : g_pass2
         assign d[2*NG]   = src[4*NG];
         assign d[2*NG+1] = src[4*NG+1];
      end else if (REM == 1) begin : g_pass1
         assign d[2*NG] = src[4*NG];
      end

      always_ff @(posedge clk) q <= d;
   end

   assign sum_o = g_lev[NLEV-1].q[0];
   assign car_o = g_lev[NLEV-1].q[1];
endmodule

// File: rtl/booth_mul_pipe.sv
module booth_mul_pipe #(
   parameter int W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [W-1:0]    in_a,
   input  logic [W-1:0]    in_b,
   output logic            out_valid,
   output logic [2*W-1:0]  out_p
);
   localparam int PW  = 2 * W;
   localparam int NPP = W / 2;
   localparam int NR  = NPP + 2;
   localparam int LAT = booth_pkg::level_count(NR);

   if (W < 4 || (W % 2) != 0) begin : g_bad_width
      $error("booth_mul_pipe: W must be even and at least 4");
   end

   logic [NR-1:0][PW-1:0] rows;
   logic [PW-1:0]         sum_q;
   logic [PW-1:0]         car_q;
   logic [LAT-1:0]        vq;

   booth_row_gen #(.W(W)) u_rows (
      .x      (in_a),
      .y      (in_b),
      .rows_o (rows)
   );

   booth_ctree #(.NR(NR), .PW(PW)) u_tree (
      .clk    (clk),
      .rows_i (rows),
      .sum_o  (sum_q),
      .car_o  (car_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vq <= '0;
      end else begin
         vq[0] <= in_valid;
         for (int k = 1; k < LAT; k++) vq[k] <= vq[k-1];
      end
   end

   // Carry-propagate adder after the last register bank.
   assign out_p     = sum_q + car_q;
   assign out_valid = vq[LAT-1];
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
   parameter int W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [W-1:0]    in_a,
   input logic [W-1:0]    in_b,
   input logic            out_valid,
   input logic [2*W-1:0]  out_p
);
   localparam int PW  = 2 * W;
   localparam int LAT = booth_pkg::level_count(W / 2 + 2);
   localparam logic [W-1:0]  MINV = {1'b1, {(W-1){1'b0}}};
   localparam logic [PW-1:0] MMPROD = {2'b01, {(PW-2){1'b0}}};

   logic signed [PW-1:0] prod_now;
   logic signed [PW-1:0] rp [LAT];
   logic [LAT-1:0]       rv;
   logic [LAT-1:0]       rnz;
   logic [LAT-1:0]       rsg;
   logic [LAT-1:0]       rmm;

   assign prod_now = $signed(in_a) * $signed(in_b);

   always_ff @(posedge clk) begin
      rp[0]  <= prod_now;
      rnz[0] <= (in_a != '0) && (in_b != '0);
      rsg[0] <= in_a[W-1] ^ in_b[W-1];
      rmm[0] <= (in_a == MINV) && (in_b == MINV);
      for (int k = 1; k < LAT; k++) begin
         rp[k]  <= rp[k-1];
         rnz[k] <= rnz[k-1];
         rsg[k] <= rsg[k-1];
         rmm[k] <= rmm[k-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rv <= '0;
      end else begin
         rv[0] <= in_valid;
         for (int k = 1; k < LAT; k++) rv[k] <= rv[k-1];
      end
   end

   AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_p == rp[LAT-1])); // R1

   AST_PRODUCT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && rnz[LAT-1]) |-> (out_p[PW-1] == rsg[LAT-1])); // R1

   AST_VALID_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == rv[LAT-1]); // R2

   AST_RESET_IDLE: assert property (@(posedge clk)
      $rose(rst_n) |-> !out_valid); // R3

   AST_MIN_SQUARE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && rmm[LAT-1]) |-> (out_p == MMPROD)); // R5
endmodule

bind booth_mul_pipe booth_mul_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_a      (in_a),
   .in_b      (in_b),
   .out_valid (out_valid),
   .out_p     (out_p)
);

// File: tb/sim_booth_mul_pipe.sv
`timescale 1ns/1ps
module sim_booth_mul_pipe;
   localparam int W   = 6;
   localparam int PW  = 2 * W;
   localparam int LAT = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [W-1:0]  in_a = '0;
   logic [W-1:0]  in_b = '0;
   logic          out_valid;
   logic [PW-1:0] out_p;

   int errors = 0;
   int checks = 0;
   int slot = 0;

   logic          ring_v [8];
   logic [PW-1:0] ring_p [8];
   string         ring_t [8];

   booth_mul_pipe #(.W(W)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_a      (in_a),
      .in_b      (in_b),
      .out_valid (out_valid),
      .out_p     (out_p)
   );

   always #10 clk = ~clk;

   task automatic clear_ring();
      for (int k = 0; k < 8; k++) begin
         ring_v[k] = 1'b0;
         ring_p[k] = '0;
         ring_t[k] = "R7";
      end
   endtask

   task automatic check_idle(input string tag);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL %s: out_valid=%b expected 0", tag, out_valid);
      end
   endtask

   // One cycle: check the slot launched LAT cycles ago, then launch a new one.
   task automatic step(input logic v, input int a, input int b, input string tag);
      int idx;
      int prod;
      @(negedge clk);
      idx = (slot - LAT) & 7;
      checks++;
      if (out_valid !== ring_v[idx]) begin
         errors++;
         $display("FAIL R2/%s: out_valid=%b expected %b", ring_t[idx], out_valid, ring_v[idx]);
      end
      if (ring_v[idx]) begin
         checks++;
         if (out_p !== ring_p[idx]) begin
            errors++;
            $display("FAIL %s: out_p=%h expected %h", ring_t[idx], out_p, ring_p[idx]);
         end
      end
      prod = a * b;
      in_valid = v;
      in_a = W'(a);
      in_b = W'(b);
      ring_v[slot & 7] = v;
      ring_p[slot & 7] = PW'(prod);
      ring_t[slot & 7] = v ? tag : "R7";
      slot++;
   endtask

   initial begin
      clear_ring();
      repeat (3) @(negedge clk);
      check_idle("R3");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R3");

      // R1 worked example: 011001 x 101110
      step(1'b1, 25, -18, "R1");
      step(1'b1, -18, 25, "R1");
      // R5 extreme operands
      step(1'b1, -32, -32, "R5");
      step(1'b1, -32, 31, "R5");
      step(1'b1, 31, 31, "R5");
      step(1'b1, 31, -32, "R5");
      step(1'b0, -32, -32, "R7");

      // R4 row selection seen through fixed multiplicands
      for (int b = -32; b < 32; b++) step(1'b1, 1, b, "R4");
      for (int b = -32; b < 32; b++) step(1'b1, -1, b, "R4");
      for (int b = -32; b < 32; b++) step(1'b1, 13, b, "R4");
      for (int b = -32; b < 32; b++) step(1'b1, -13, b, "R4");

      // R6 every pair, one per cycle
      for (int a = -32; a < 32; a++)
         for (int b = -32; b < 32; b++)
            step(1'b1, a, b, "R6");

      // R7 idle cycles carry garbage operands
      for (int n = 0; n < 200; n++)
         step((n % 3) != 1, (n * 7) % 64 - 32, (n * 11) % 64 - 32, "R7");

      // R3 reset in the middle of a stream
      for (int n = 0; n < 4; n++) step(1'b1, n + 5, -n - 9, "R6");
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b1;
      clear_ring();
      @(negedge clk);
      check_idle("R3");
      @(negedge clk);
      check_idle("R3");
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R3");
      step(1'b1, 25, -18, "R1");
      step(1'b1, -7, 9, "R1");
      for (int n = 0; n < LAT + 2; n++) step(1'b0, 0, 0, "R7");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: cycles=100000 expected completion earlier");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule